// File: doc/BRIEF.md
# Dual-Device Asynchronous Memory Bus Controller

This controller connects a host to two asynchronous memories that share one 16-bit data bus and one address bus. One memory is a NOR-style flash with 22 address bits. The other is a pseudo-static RAM with 20 address bits. The host issues one request at a time through a small valid/ready interface. Each request carries a read/write flag, a device select, a word address, per-byte enables and write data. The controller then runs a timed asynchronous cycle on the selected device. When the cycle ends it returns the read data together with a one-cycle done pulse.

Every cycle follows the same sequence of states: IDLE → SETUP → STROBE → HOLD → TURN → IDLE. The SETUP state lasts one cycle, and chip enable and address are valid during it. The STROBE state keeps the output or write strobe low for `ACC_CYC` clocks. The HOLD state lasts one cycle: the strobe is released but the enable and the write data are still held. The TURN state is one idle cycle in which every enable is released.

The host can hold `pd_req` high to put the RAM into deep power-down. The controller lowers the RAM's power enable only when it is idle.
- A RAM request that arrives while the RAM is asleep takes the transition IDLE → WAKE. The WAKE state lasts `WAKE_CYC` cycles, and the access then continues with SETUP.
- When `pd_req` drops while the RAM is asleep, the controller takes IDLE → WAKE → IDLE.
- Flash accesses run normally while the RAM sleeps.

Top module: `dual_mem_bus_ctrl`

## Requirements
- R1: During a flash cycle `mem_addr` carries all 22 bits of `req_addr`. During a RAM cycle `mem_addr[21:20]` is 0 and `mem_addr[19:0]` equals `req_addr[19:0]`.
- R2: `flash_ce_n` and `ram_ce1_n` are never low in the same cycle. The device that is not addressed keeps all its enables high.
- R3: A flash read drives `flash_ce_n`=0, `flash_oe_n`=0 and `flash_we_n`=1 during STROBE. A flash write drives `flash_ce_n`=0, `flash_we_n`=0 and `flash_oe_n`=1 during STROBE. `flash_ce_n` is also low during SETUP and HOLD.
- R4: A RAM cycle drives `ram_ce1_n`=0 and `ram_ce2`=1 during SETUP, STROBE and HOLD. During STROBE, `ram_oe_n`=0 for a read or `ram_we_n`=0 for a write, and the other strobe stays high.
- R5: The controller accepts a request at a clock edge where `req_valid`=1 and `req_ready`=1. From that edge it takes one SETUP cycle, `ACC_CYC` STROBE cycles, one HOLD cycle with `rsp_done`=1, and one TURN cycle. `req_ready` then returns to 1. With no wake-up, `req_ready` is low for `ACC_CYC`+3 cycles.
- R6: In a RAM cycle, `ram_ub_n` is low exactly when `req_be[1]` (bits 15:8) is set, and `ram_lb_n` is low exactly when `req_be[0]` (bits 7:0) is set. On a RAM read, each byte lane whose enable bit is clear returns 0. On a flash read, `req_be` has no effect and all 16 bits are returned.
- R7: If the controller is idle with the RAM awake, `pd_req`=1 and no request pending, `ram_ce2` goes low at the next edge. It stays low through any flash accesses.
- R8: A RAM request accepted while the RAM is asleep first raises `ram_ce2` and spends `WAKE_CYC` cycles in WAKE, with `ram_ce1_n` high, before SETUP. In that case `req_ready` is low for `WAKE_CYC`+`ACC_CYC`+3 cycles. If `pd_req` falls while the RAM is asleep and idle, `req_ready` is low for `WAKE_CYC` cycles.
- R9: `mem_dq_oe` is 1 only during the STROBE and HOLD states of a write, and `mem_dq_out` then equals the write data. `mem_dq_oe` is 0 whenever any output enable is low.
- R10: While `rst_n` is low, every chip enable, output enable, write enable and byte enable is high, `ram_ce2` is 1 and `mem_dq_oe` is 0.
- R11: Read data is sampled in the last STROBE cycle and appears on `rsp_rdata` while `rsp_done`=1. It keeps that value until the next read completes.
- R12: If a request and a rise of `pd_req` occur in the same idle cycle, the request is served first and power-down starts only after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_psram | input | 1 | 1 = RAM, 0 = flash |
| req_addr | input | 22 | Word address |
| req_be | input | 2 | Byte enables, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| pd_req | input | 1 | Deep power-down request for the RAM |
| mem_addr | output | 22 | Shared address bus |
| mem_dq_out | output | 16 | Data bus, driven value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data bus, sampled value |
| flash_ce_n | output | 1 | Flash chip enable |
| flash_oe_n | output | 1 | Flash output enable |
| flash_we_n | output | 1 | Flash write enable |
| ram_ce1_n | output | 1 | RAM select |
| ram_ce2 | output | 1 | RAM power enable, low = deep power-down |
| ram_oe_n | output | 1 | RAM output enable |
| ram_we_n | output | 1 | RAM write enable |
| ram_ub_n | output | 1 | RAM upper byte enable |
| ram_lb_n | output | 1 | RAM lower byte enable |

## Verification
Two functions can fall into the same idle cycle: accepting a RAM request, and entering deep power-down. The bench raises `pd_req` on the same clock edge that it presents a RAM read. The following cycle must show SETUP with `ram_ce2` still high. `ram_ce2` must drop only in the first idle cycle after TURN. A second collision comes from releasing `pd_req` while the RAM sleeps. The bench checks that the wake-only path keeps `req_ready` low for exactly `WAKE_CYC` cycles and starts no cycle on the bus. A timeline model in the bench judges every pin on every clock.

// File: rtl/dmb_pkg.sv
package dmb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN
    } dmb_state_e;

    typedef struct packed {
        logic write;
        logic psram;
    } dmb_op_t;
endpackage

// File: rtl/dmb_timer.sv
module dmb_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dmb_seq.sv
module dmb_seq
    import dmb_pkg::*;
#(
    parameter int FA_W     = 22,
    parameter int DW       = 16,
    parameter int BE_W     = 2,
    parameter int CNT_W    = 6,
    parameter int ACC_CYC  = 18,
    parameter int WAKE_CYC = 38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_psram,
    input  logic [FA_W-1:0]  req_addr,
    input  logic [BE_W-1:0]  req_be,
    input  logic [DW-1:0]    req_wdata,
    input  logic             pd_req,
    input  logic             expired,
    output dmb_state_e       state_q,
    output dmb_op_t          op_q,
    output logic [FA_W-1:0]  addr_q,
    output logic [BE_W-1:0]  be_q,
    output logic [DW-1:0]    wdata_q,
    output logic             sleep_q,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);
    dmb_state_e state_d;
    logic       pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (req_psram && sleep_q) ? ST_WAKE : ST_SETUP;
                end else if (sleep_q && !pd_req) begin
                    state_d = ST_WAKE;
                end
            end
            ST_WAKE:   if (expired) state_d = pend_q ? ST_SETUP : ST_IDLE;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (expired) state_d = ST_HOLD;
            ST_HOLD:   state_d = ST_TURN;
            ST_TURN:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Timer is loaded on entry to WAKE and on the SETUP -> STROBE step.
    assign tmr_load = (state_q == ST_SETUP) ||
                      ((state_q == ST_IDLE) && (state_d == ST_WAKE));
    assign tmr_val  = (state_q == ST_SETUP) ? CNT_W'(ACC_CYC - 1)
                                            : CNT_W'(WAKE_CYC - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            pend_q  <= 1'b0;
            sleep_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            pend_q <= req_valid;
            if (req_valid) begin
                op_q.write <= req_write;
                op_q.psram <= req_psram;
                addr_q     <= req_addr;
                be_q       <= req_be;
                wdata_q    <= req_wdata;
                if (req_psram) sleep_q <= 1'b0;
            end else if (sleep_q && !pd_req) begin
                sleep_q <= 1'b0;
            end else if (!sleep_q && pd_req) begin
                sleep_q <= 1'b1;
            end
        end
    end

    // R12: power-down never starts while a cycle is under way
    p_sleep_only_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_q) |-> ($past(state_q) == ST_IDLE) && !$past(req_valid));
    // R8: a wake period always ends with the RAM awake
    p_wake_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |-> !sleep_q);
endmodule

// File: rtl/dmb_pins.sv
module dmb_pins
    import dmb_pkg::*;
#(
    parameter int FA_W = 22,
    parameter int PA_W = 20,
    parameter int DW   = 16,
    parameter int BE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dmb_state_e       state_q,
    input  dmb_op_t          op_q,
    input  logic [FA_W-1:0]  addr_q,
    input  logic [BE_W-1:0]  be_q,
    input  logic [DW-1:0]    wdata_q,
    input  logic             sleep_q,
    input  logic             expired,
    input  logic [DW-1:0]    mem_dq_in,
    output logic             req_ready,
    output logic             rsp_done,
    output logic [DW-1:0]    rsp_rdata,
    output logic [FA_W-1:0]  mem_addr,
    output logic [DW-1:0]    mem_dq_out,
    output logic             mem_dq_oe,
    output logic             flash_ce_n,
    output logic             flash_oe_n,
    output logic             flash_we_n,
    output logic             ram_ce1_n,
    output logic             ram_ce2,
    output logic             ram_oe_n,
    output logic             ram_we_n,
    output logic             ram_ub_n,
    output logic             ram_lb_n
);
    logic          act, strobe, fl_sel, ram_sel;
    logic [DW-1:0] lane_mask;

    assign act     = (state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                     (state_q == ST_HOLD);
    assign strobe  = (state_q == ST_STROBE);
    assign fl_sel  = act && !op_q.psram;
    assign ram_sel = act && op_q.psram;

    always_comb begin
        flash_ce_n = !fl_sel;
        flash_oe_n = !(fl_sel && strobe && !op_q.write);
        flash_we_n = !(fl_sel && strobe && op_q.write);
        ram_ce1_n  = !ram_sel;
        ram_oe_n   = !(ram_sel && strobe && !op_q.write);
        ram_we_n   = !(ram_sel && strobe && op_q.write);
        ram_ub_n   = !(ram_sel && be_q[BE_W-1]);
        ram_lb_n   = !(ram_sel && be_q[0]);
        ram_ce2    = !sleep_q;
        mem_dq_oe  = op_q.write && (strobe || (state_q == ST_HOLD));
        mem_dq_out = wdata_q;
        req_ready  = (state_q == ST_IDLE);
        rsp_done   = (state_q == ST_HOLD);
    end

    always_comb begin
        mem_addr = addr_q;
        if (op_q.psram) mem_addr[FA_W-1:PA_W] = '0;
    end

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = (op_q.psram && !be_q[g]) ? 8'h00 : 8'hFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (strobe && expired && !op_q.write) begin
            rsp_rdata <= mem_dq_in & lane_mask;
        end
    end

    p_single_device_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flash_ce_n || ram_ce1_n);
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_oe_n || flash_we_n) && (ram_oe_n || ram_we_n));
    p_dpd_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce2 |-> ram_ce1_n);
    p_bus_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (flash_oe_n && ram_oe_n));
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_we_n || !ram_we_n) |=> mem_dq_oe && $stable(mem_dq_out));
    p_ram_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce1_n |-> (mem_addr[FA_W-1:PA_W] == '0));
endmodule

// File: rtl/dual_mem_bus_ctrl.sv
module dual_mem_bus_ctrl
    import dmb_pkg::*;
#(
    parameter int FA_W     = 22,
    parameter int PA_W     = 20,
    parameter int DW       = 16,
    parameter int ACC_CYC  = 18,
    parameter int WAKE_CYC = 38
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic            req_psram,
    input  logic [FA_W-1:0] req_addr,
    input  logic [DW/8-1:0] req_be,
    input  logic [DW-1:0]   req_wdata,
    output logic [DW-1:0]   rsp_rdata,
    output logic            rsp_done,
    input  logic            pd_req,
    output logic [FA_W-1:0] mem_addr,
    output logic [DW-1:0]   mem_dq_out,
    output logic            mem_dq_oe,
    input  logic [DW-1:0]   mem_dq_in,
    output logic            flash_ce_n,
    output logic            flash_oe_n,
    output logic            flash_we_n,
    output logic            ram_ce1_n,
    output logic            ram_ce2,
    output logic            ram_oe_n,
    output logic            ram_we_n,
    output logic            ram_ub_n,
    output logic            ram_lb_n
);
    localparam int BE_W    = DW / 8;
    localparam int CNT_MAX = (ACC_CYC > WAKE_CYC) ? ACC_CYC : WAKE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    dmb_state_e       state_q;
    dmb_op_t          op_q;
    logic [FA_W-1:0]  addr_q;
    logic [BE_W-1:0]  be_q;
    logic [DW-1:0]    wdata_q;
    logic             sleep_q, tmr_load, expired;
    logic [CNT_W-1:0] tmr_val;

    dmb_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(expired)
    );

    dmb_seq #(
        .FA_W(FA_W), .DW(DW), .BE_W(BE_W), .CNT_W(CNT_W),
        .ACC_CYC(ACC_CYC), .WAKE_CYC(WAKE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_write(req_write), .req_psram(req_psram), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .pd_req(pd_req),
        .expired(expired), .state_q(state_q), .op_q(op_q), .addr_q(addr_q),
        .be_q(be_q), .wdata_q(wdata_q), .sleep_q(sleep_q),
        .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    dmb_pins #(.FA_W(FA_W), .PA_W(PA_W), .DW(DW), .BE_W(BE_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .state_q(state_q), .op_q(op_q),
        .addr_q(addr_q), .be_q(be_q), .wdata_q(wdata_q), .sleep_q(sleep_q),
        .expired(expired), .mem_dq_in(mem_dq_in), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
        .flash_we_n(flash_we_n), .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_ub_n(ram_ub_n),
        .ram_lb_n(ram_lb_n)
    );

    // R10: while reset is held no device is selected
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r10: assert (flash_ce_n && ram_ce1_n && ram_ce2 && !mem_dq_oe);
        end
    end
endmodule

// File: tb/sim_dual_mem_bus_ctrl.sv
module sim_dual_mem_bus_ctrl;
    localparam int ACC  = 5;
    localparam int WAKE = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_psram = 1'b0, pd_req = 1'b0;
    logic [21:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, mem_dq_oe;
    logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [21:0] mem_addr;
    logic        flash_ce_n, flash_oe_n, flash_we_n;
    logic        ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_ub_n, ram_lb_n;

    int nchk = 0, nfail = 0, cyc = 0;

    always #2 clk = ~clk;

    dual_mem_bus_ctrl #(.ACC_CYC(ACC), .WAKE_CYC(WAKE)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_psram(req_psram), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .pd_req(pd_req), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
        .ram_ce1_n(ram_ce1_n), .ram_ce2(ram_ce2), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .ram_ub_n(ram_ub_n), .ram_lb_n(ram_lb_n)
    );

    function automatic logic [15:0] fval(input logic [21:0] a);
        return a[15:0] ^ {10'h0, a[21:16]} ^ 16'hA55A;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // device models: flash returns a function of the address, RAM is an array
    logic [15:0] dev_mem [1024];
    logic [15:0] ref_mem [1024];
    initial for (int i = 0; i < 1024; i++) begin dev_mem[i] = '0; ref_mem[i] = '0; end

    always @* begin
        mem_dq_in = 16'hBEEF;
        if (!flash_ce_n && !flash_oe_n) begin
            mem_dq_in = fval(mem_addr);
        end else if (!ram_ce1_n && ram_ce2 && !ram_oe_n) begin
            mem_dq_in = dev_mem[mem_addr[9:0]];
            if (ram_ub_n) mem_dq_in[15:8] = 8'hEE;
            if (ram_lb_n) mem_dq_in[7:0]  = 8'hEE;
        end
    end

    always @(posedge ram_we_n) begin
        if (rst_n && !ram_ce1_n && ram_ce2 && mem_dq_oe) begin
            if (!ram_ub_n) dev_mem[mem_addr[9:0]][15:8] = mem_dq_out[15:8];
            if (!ram_lb_n) dev_mem[mem_addr[9:0]][7:0]  = mem_dq_out[7:0];
        end
    end

    // timeline reference: mt counts cycles since acceptance, 0 = idle
    int          mt = 0, mw = 0;
    bit          mwo = 0, mps = 0, mwr = 0, msleep = 0;
    logic [1:0]  mbe = '0;
    logic [21:0] maddr = '0;
    logic [15:0] mwdata = '0, mexp = '0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mt = 0; msleep = 0;
        end else if (mt == 0) begin
            if (req_valid) begin
                mps = req_psram; mwr = req_write; mbe = req_be; maddr = req_addr;
                mwdata = req_wdata; mwo = 0;
                mw = (req_psram && msleep) ? WAKE : 0;
                if (req_psram) msleep = 0;
                mt = 1;
                if (mwr && mps) begin
                    if (mbe[1]) ref_mem[maddr[9:0]][15:8] = mwdata[15:8];
                    if (mbe[0]) ref_mem[maddr[9:0]][7:0]  = mwdata[7:0];
                end else if (!mwr) begin
                    if (!mps) mexp = fval(maddr);
                    else begin
                        mexp = ref_mem[maddr[9:0]];
                        if (!mbe[1]) mexp[15:8] = 8'h00;
                        if (!mbe[0]) mexp[7:0]  = 8'h00;
                    end
                end
            end else if (msleep && !pd_req) begin
                mwo = 1; mw = WAKE; msleep = 0; mt = 1;
            end else if (!msleep && pd_req) begin
                msleep = 1;
            end
        end else begin
            if ((mwo && mt == mw) || (!mwo && mt == mw + ACC + 3)) mt = 0;
            else mt++;
        end
    end

    // compare every pin against the timeline on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit setup, strobe, hold, act;
            setup  = !mwo && mt == mw + 1;
            strobe = !mwo && mt >= mw + 2 && mt <= mw + 1 + ACC;
            hold   = !mwo && mt == mw + 2 + ACC;
            act    = setup || strobe || hold;
            check("R2", {31'd0, !flash_ce_n && !ram_ce1_n}, 32'd0);
            check("R3", {29'd0, flash_ce_n, flash_oe_n, flash_we_n},
                  {29'd0, !(act && !mps), !(strobe && !mps && !mwr), !(strobe && !mps && mwr)});
            check("R4", {29'd0, ram_ce1_n, ram_oe_n, ram_we_n},
                  {29'd0, !(act && mps), !(strobe && mps && !mwr), !(strobe && mps && mwr)});
            check("R6", {30'd0, ram_ub_n, ram_lb_n},
                  {30'd0, !(act && mps && mbe[1]), !(act && mps && mbe[0])});
            check("R7", {31'd0, ram_ce2}, {31'd0, !msleep});
            check("R9", {31'd0, mem_dq_oe}, {31'd0, mwr && (strobe || hold)});
            check("R5", {30'd0, req_ready, rsp_done}, {30'd0, mt == 0, hold});
            if (act) check("R1", {10'd0, mem_addr}, {10'd0, mps ? {2'b00, maddr[19:0]} : maddr});
            if (mwr && (strobe || hold)) check("R9", {16'd0, mem_dq_out}, {16'd0, mwdata});
            if (hold && !mwr) check("R11", {16'd0, rsp_rdata}, {16'd0, mexp});
        end
    end

    task automatic host_op(input bit wr, input bit ps, input logic [21:0] a,
                           input logic [1:0] be, input logic [15:0] d, output int busy);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_psram = ps; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        busy = 0;
        while (!req_ready) begin busy++; @(negedge clk); end
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int busy;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {23'd0, flash_ce_n, flash_oe_n, flash_we_n, ram_ce1_n, ram_oe_n,
                      ram_we_n, ram_ub_n, ram_lb_n, ram_ce2}, 32'h1FF);
        check("R10", {31'd0, mem_dq_oe}, 32'd0);
        rst_n = 1;

        host_op(1, 0, 22'h3F0010, 2'b11, 16'h1234, busy);            // R3 flash write
        check("R5", busy, ACC + 3);
        host_op(0, 0, 22'h2ABCDE, 2'b00, 16'h0, busy);               // R6 be ignored on flash
        check("R11", {16'd0, rsp_rdata}, {16'd0, fval(22'h2ABCDE)});
        host_op(1, 1, 22'h300005, 2'b11, 16'h5A3C, busy);            // R1 top bits dropped
        check("R11", {16'd0, rsp_rdata}, {16'd0, fval(22'h2ABCDE)}); // held over a write
        host_op(0, 1, 22'h000005, 2'b11, 16'h0, busy);
        check("R4", {16'd0, rsp_rdata}, 32'h5A3C);
        host_op(1, 1, 22'h000005, 2'b01, 16'hABCD, busy);            // R6 lower lane only
        host_op(0, 1, 22'h000005, 2'b11, 16'h0, busy);
        check("R6", {16'd0, rsp_rdata}, 32'h5ACD);
        host_op(0, 1, 22'h000005, 2'b10, 16'h0, busy);
        check("R6", {16'd0, rsp_rdata}, 32'h5A00);

        // R7: enter deep power-down, flash still usable
        pd_req = 1;
        repeat (2) @(negedge clk);
        check("R7", {31'd0, ram_ce2}, 32'd0);
        host_op(0, 0, 22'h10FFFF, 2'b11, 16'h0, busy);
        check("R7", {31'd0, ram_ce2}, 32'd0);
        // R8: RAM access while asleep pays the wake-up time
        host_op(0, 1, 22'h000005, 2'b11, 16'h0, busy);
        check("R8", busy, WAKE + ACC + 3);
        check("R8", {16'd0, rsp_rdata}, 32'h5ACD);
        @(negedge clk);
        check("R7", {31'd0, ram_ce2}, 32'd0);
        // R8: release of pd_req alone
        pd_req = 0;
        busy = 0;
        @(negedge clk);
        while (!req_ready) begin busy++; @(negedge clk); end
        check("R8", busy, WAKE);
        check("R8", {31'd0, ram_ce2}, 32'd1);

        // R12: request and power-down rise in the same idle cycle
        @(negedge clk);
        pd_req = 1; req_valid = 1; req_write = 0; req_psram = 1;
        req_addr = 22'h000005; req_be = 2'b11;
        @(negedge clk);
        req_valid = 0;
        check("R12", {30'd0, ram_ce1_n, ram_ce2}, 32'h1);
        while (!req_ready) @(negedge clk);
        check("R12", {16'd0, rsp_rdata}, 32'h5ACD);
        @(negedge clk);
        check("R12", {31'd0, ram_ce2}, 32'd0);
        pd_req = 0;
        repeat (WAKE + 2) @(negedge clk);

        // R9: write followed at once by a read on the other device
        host_op(1, 1, 22'h000100, 2'b11, 16'hC0DE, busy);
        host_op(0, 0, 22'h000100, 2'b11, 16'h0, busy);
        check("R9", {16'd0, rsp_rdata}, {16'd0, fval(22'h000100)});
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule